// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the bus-master half of one DMA channel. Once a channel has been armed with a start address, a cycle count and a transfer kind, the sequencer waits for the peripheral's request. It then asks the processor for the system bus with a hold request and waits for the hold grant. After that it runs one transfer cycle per byte.

Every transfer cycle steps through five states, S0 to S4. S0 takes the bus. In S1 the upper address byte goes out on the shared data pins under an address strobe, for an external latch to capture, while the lower address byte sits on dedicated address pins. In S2 the data strobes are raised for the kind selected. S3 holds those strobes while the ready input is low. In S4 the address steps up and the remaining count steps down. The peripheral acknowledge is high from S1 to S4 of every cycle. The terminal-count output flags the last programmed cycle, and the mark output flags every 128th cycle since the channel was armed.

In burst mode the bus is kept across back-to-back cycles while the request stays high. In single mode the bus is handed back after every byte. All strobe and address outputs are active high. Each output is qualified by the bus-master enable, which stands in for the tri-state release. An arm pulse is accepted only while the sequencer is idle.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, hrq, aen, adstb, data_oe, dack, tc, mark and all four data strobes are low.
- R2: With the channel armed and dreq high, hrq rises and aen stays low until hlda is sampled high. aen is then high from the next cycle for as long as the block is bus master.
- R3: During S1 of each transfer cycle, adstb and data_oe are high, data_out carries address bits 15..8, and addr_lo carries bits 7..0. Outside S1, adstb and data_oe are low.
- R4: A read cycle (kind code 2'b10) raises mem_rd and io_wr together in S2 and S3, with mem_wr and io_rd low.
- R5: A write cycle (kind code 2'b01) raises io_rd and mem_wr together in S2 and S3, with mem_rd and io_wr low.
- R6: A verify cycle (kind code 2'b00, and also the unused code 2'b11) asserts dack for S1 to S4 of every cycle and never raises any of the four data strobes.
- R7: While ready is low in S3, the block stays in S3 with its data strobes held, so each low cycle lengthens the transfer cycle by one clock. Before S3, ready has no effect.
- R8: The address presented in each cycle is one above the address of the previous cycle, wrapping modulo 2^16. The first cycle uses the armed start address.
- R9: With count value N-1 armed, exactly N cycles run. tc is high during the N-th cycle only. Afterwards hrq drops and the channel stays idle even if dreq remains high.
- R10: mark is high during every cycle whose 1-based index since arming is a multiple of 128, and low during all other cycles.
- R11: In burst mode, consecutive cycles follow each other with adstb every 5 clocks and hrq held high. If dreq is low at S4, hrq drops. The transfer resumes at the next address once dreq returns.
- R12: In single mode, hrq drops after every cycle, so an N-cycle transfer produces N falling edges of hrq.
- R13: dack is high only in S1 to S4, and every data strobe is accompanied by dack and aen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Load pulse for the channel setup, taken only when idle |
| arm_addr | input | 16 | Start memory address |
| arm_count | input | 14 | Cycle count minus one |
| arm_kind | input | 2 | 2'b10 read, 2'b01 write, 2'b00/2'b11 verify |
| arm_burst | input | 1 | 1 keeps the bus between cycles, 0 releases it per byte |
| dreq | input | 1 | Peripheral request |
| hlda | input | 1 | Hold grant from the processor |
| ready | input | 1 | Memory ready, low inserts wait states in S3 |
| hrq | output | 1 | Hold request to the processor |
| aen | output | 1 | Bus-master enable, qualifies all bus outputs |
| adstb | output | 1 | Strobe for the upper address byte latch |
| addr_lo | output | 8 | Address bits 7..0 |
| data_out | output | 8 | Address bits 15..8 during S1 |
| data_oe | output | 1 | Drive enable for data_out |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| dack | output | 1 | Peripheral acknowledge |
| tc | output | 1 | Terminal count, last cycle |
| mark | output | 1 | Every-128th-cycle flag |

## Verification
The bench builds the block with its defaults: a 16-bit address split 8/8, a 14-bit count and a mark period of 128. Because the period is a power of two, the wrapping-counter variant of the mark divider is the one built. A 260-cycle verify run reaches two marks within the cycle budget. Start addresses just below 16'hFFFF make the upper byte on the data pins change and wrap within a short run. Driving hlda by hand exposes the hold wait, and holding ready low for a fixed number of clocks produces a measurable stretch in the spacing between address strobes.

// File: rtl/dma_xfer_seq_pkg.sv
package dma_xfer_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_HOLD = 3'd1,
      ST_S0   = 3'd2,
      ST_S1   = 3'd3,
      ST_S2   = 3'd4,
      ST_S3   = 3'd5,
      ST_S4   = 3'd6
   } seq_st_t;

   localparam logic [1:0] KIND_VERIFY = 2'b00;
   localparam logic [1:0] KIND_WRITE  = 2'b01;
   localparam logic [1:0] KIND_READ   = 2'b10;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
   import dma_xfer_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    armed,
   input  logic    dreq,
   input  logic    hlda,
   input  logic    ready,
   input  logic    burst,
   input  logic    last,
   output seq_st_t state,
   output logic    step
);

   seq_st_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (armed && dreq) nxt = ST_HOLD;
         ST_HOLD: if (hlda) nxt = ST_S0;
         ST_S0:   nxt = ST_S1;
         ST_S1:   nxt = ST_S2;
         ST_S2:   nxt = ST_S3;
         ST_S3:   if (ready) nxt = ST_S4;
         ST_S4: begin
            if (last)               nxt = ST_IDLE;
            else if (burst && dreq) nxt = ST_S0;
            else                    nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign step = (state == ST_S4);

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [CNT_W-1:0]  ld_count,
   input  logic [1:0]        ld_kind,
   input  logic              ld_burst,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        kind,
   output logic              burst,
   output logic              armed,
   output logic              last
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         remain <= '0;
         kind   <= 2'b00;
         burst  <= 1'b0;
         armed  <= 1'b0;
      end else if (load) begin
         addr   <= ld_addr;
         remain <= ld_count;
         kind   <= ld_kind;
         burst  <= ld_burst;
         armed  <= 1'b1;
      end else if (step) begin
         addr <= addr + ADDR_W'(1);
         if (remain != CNT_ZERO) remain <= remain - CNT_ONE;
         else                    armed  <= 1'b0;
      end
   end

   assign last = (remain == CNT_ZERO);

endmodule

// File: rtl/dma_seq_mark.sv
module dma_seq_mark #(
   parameter int PERIOD = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic hit
);

   localparam int          CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam bit          POW2 = ((PERIOD & (PERIOD - 1)) == 0);
   localparam logic [CW-1:0] TOP = CW'(PERIOD - 1);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clear) cnt <= '0;
            else if (step)  cnt <= cnt + CW'(1);
         end
      end else begin : g_modulo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clear) cnt <= '0;
            else if (step)  cnt <= (cnt == TOP) ? '0 : cnt + CW'(1);
         end
      end
   endgenerate

   assign hit = (cnt == TOP);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_xfer_seq_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int LO_W        = 8,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 14,
   parameter int MARK_PERIOD = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic [CNT_W-1:0]  arm_count,
   input  logic [1:0]        arm_kind,
   input  logic              arm_burst,
   input  logic              dreq,
   input  logic              hlda,
   input  logic              ready,
   output logic              hrq,
   output logic              aen,
   output logic              adstb,
   output logic [LO_W-1:0]   addr_lo,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              dack,
   output logic              tc,
   output logic              mark
);

   localparam int HI_W = ADDR_W - LO_W;

   generate
      if (HI_W != DATA_W) begin : g_bad_split
         $error("address split must equal LO_W + DATA_W");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (MARK_PERIOD < 2) begin : g_bad_mark
         $error("MARK_PERIOD must be at least 2");
      end
   endgenerate

   seq_st_t           state;
   logic              step;
   logic              armed;
   logic              last;
   logic              burst;
   logic [1:0]        kind;
   logic [ADDR_W-1:0] addr;
   logic              mark_now;
   logic              load;
   logic              master;
   logic              xfer;

   assign load = arm && (state == ST_IDLE);

   dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .load(load),
      .ld_addr(arm_addr), .ld_count(arm_count), .ld_kind(arm_kind),
      .ld_burst(arm_burst), .step(step),
      .addr(addr), .kind(kind), .burst(burst), .armed(armed), .last(last)
   );

   dma_seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .armed(armed), .dreq(dreq), .hlda(hlda),
      .ready(ready), .burst(burst), .last(last), .state(state), .step(step)
   );

   dma_seq_mark #(.PERIOD(MARK_PERIOD)) u_mark (
      .clk(clk), .rst_n(rst_n), .clear(load), .step(step), .hit(mark_now)
   );

   assign master   = (state == ST_S0) || (state == ST_S1) || (state == ST_S2) ||
                     (state == ST_S3) || (state == ST_S4);
   assign xfer     = (state == ST_S2) || (state == ST_S3);

   assign hrq      = (state != ST_IDLE);
   assign aen      = master;
   assign adstb    = (state == ST_S1);
   assign data_oe  = (state == ST_S1);
   assign data_out = (state == ST_S1) ? addr[ADDR_W-1 -: DATA_W] : '0;
   assign addr_lo  = master ? addr[LO_W-1:0] : '0;
   assign dack     = master && (state != ST_S0);
   assign mem_rd   = xfer && (kind == KIND_READ);
   assign io_wr    = xfer && (kind == KIND_READ);
   assign mem_wr   = xfer && (kind == KIND_WRITE);
   assign io_rd    = xfer && (kind == KIND_WRITE);
   assign tc       = dack && last;
   assign mark     = dack && mark_now;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic hlda,
   input logic ready,
   input logic hrq,
   input logic aen,
   input logic adstb,
   input logic data_oe,
   input logic mem_rd,
   input logic mem_wr,
   input logic io_rd,
   input logic io_wr,
   input logic dack,
   input logic tc,
   input logic mark
);

   logic any_stb;
   assign any_stb = mem_rd | mem_wr | io_rd | io_wr;

   a_r2_grant_before_master: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aen) |-> $past(hlda) && hrq);

   a_r3_strobe_drives_data: assert property (@(posedge clk) disable iff (!rst_n)
      adstb |-> data_oe && aen && dack);

   a_r4_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> io_wr && !mem_wr && !io_rd);

   a_r5_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> io_rd && !mem_rd && !io_wr);

   a_r7_wait_keeps_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stb && !ready) |=> any_stb);

   a_r9_release_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dack) && $past(tc)) |-> !hrq);

   a_r10_mark_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mark |-> dack);

   a_r13_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      any_stb |-> dack && aen);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hlda(hlda), .ready(ready), .hrq(hrq),
   .aen(aen), .adstb(adstb), .data_oe(data_oe), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .dack(dack),
   .tc(tc), .mark(mark)
);

// File: tb/dma_xfer_seq_bench.sv
`timescale 1ns/1ps
module dma_xfer_seq_bench;

   localparam logic [1:0] K_VER = 2'b00;
   localparam logic [1:0] K_WR  = 2'b01;
   localparam logic [1:0] K_RD  = 2'b10;
   localparam logic [1:0] K_ALT = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic [15:0] arm_addr = '0;
   logic [13:0] arm_count = '0;
   logic [1:0]  arm_kind = '0;
   logic arm_burst = 1'b0;
   logic dreq = 1'b0;
   logic ready = 1'b1;
   logic hlda_auto = 1'b1;
   logic hlda_man = 1'b0;
   logic hlda_q = 1'b0;
   logic hlda;

   logic hrq, aen, adstb, data_oe, mem_rd, mem_wr, io_rd, io_wr, dack, tc, mark;
   logic [7:0] addr_lo, data_out;

   int errors = 0;
   int checks = 0;
   int idx = 0;
   int n_exp = 0;
   logic [15:0] base = '0;
   logic [1:0]  kind_exp = '0;
   int stb_cycles = 0;
   int dack_cycles = 0;
   int falls = 0;
   int marks = 0;
   int cyc = 0;
   int last_cyc = -1;
   int last_gap = 0;
   logic prev_hrq = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) hlda_q <= hrq;
   assign hlda = hlda_auto ? hlda_q : hlda_man;

   dma_xfer_seq u_dma_xfer_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm), .arm_addr(arm_addr),
      .arm_count(arm_count), .arm_kind(arm_kind), .arm_burst(arm_burst),
      .dreq(dreq), .hlda(hlda), .ready(ready), .hrq(hrq), .aen(aen),
      .adstb(adstb), .addr_lo(addr_lo), .data_out(data_out), .data_oe(data_oe),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
      .dack(dack), .tc(tc), .mark(mark)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle monitor: address, tc, mark, strobe pairing
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (adstb) begin
            chk({data_out, addr_lo} == 16'(base + idx), "R3/R8 address",
                {data_out, addr_lo}, 16'(base + idx));
            chk(data_oe, "R3 data_oe", data_oe, 1);
            chk(tc == (idx == n_exp - 1), "R9 tc", tc, idx == n_exp - 1);
            chk(mark == ((idx + 1) % 128 == 0), "R10 mark", mark, (idx + 1) % 128 == 0);
            if (last_cyc >= 0) last_gap = cyc - last_cyc;
            last_cyc = cyc;
            idx++;
         end
         if (dack) dack_cycles++;
         if (mark && adstb) marks++;
         if (mem_rd | mem_wr | io_rd | io_wr) begin
            stb_cycles++;
            chk(dack && aen, "R13 strobe without ack", dack, 1);
            if (kind_exp == K_RD)
               chk({mem_rd, io_wr, mem_wr, io_rd} == 4'b1100, "R4 read strobes",
                   {mem_rd, io_wr, mem_wr, io_rd}, 4'b1100);
            else if (kind_exp == K_WR)
               chk({mem_rd, io_wr, mem_wr, io_rd} == 4'b0011, "R5 write strobes",
                   {mem_rd, io_wr, mem_wr, io_rd}, 4'b0011);
            else
               chk(1'b0, "R6 verify strobe", {mem_rd, io_wr, mem_wr, io_rd}, 0);
         end
         if (prev_hrq && !hrq) falls++;
         prev_hrq = hrq;
      end
   end

   task automatic start(input logic [15:0] a, input int n, input logic [1:0] k,
                        input logic b);
      @(negedge clk);
      base = a; n_exp = n; kind_exp = k;
      idx = 0; stb_cycles = 0; dack_cycles = 0; falls = 0; marks = 0;
      last_cyc = -1; last_gap = 0;
      arm_addr = a; arm_count = 14'(n - 1); arm_kind = k; arm_burst = b; arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic finish_wait(input string req);
      int t = 0;
      while (!(idx == n_exp && !hrq) && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 20000, req, idx, n_exp);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk({hrq, aen, adstb, data_oe, dack, tc, mark, mem_rd, mem_wr, io_rd, io_wr} == 0,
          "R1 reset outputs",
          {hrq, aen, adstb, data_oe, dack, tc, mark, mem_rd, mem_wr, io_rd, io_wr}, 0);
   endtask

   task automatic t_hold_wait;
      hlda_auto = 1'b0; hlda_man = 1'b0;
      start(16'h0300, 2, K_RD, 1'b1);
      dreq = 1'b1;
      repeat (5) @(negedge clk);
      chk(hrq == 1'b1, "R2 hrq raised", hrq, 1);
      chk(aen == 1'b0, "R2 aen waits for hlda", aen, 0);
      chk(idx == 0, "R2 no cycle before grant", idx, 0);
      hlda_man = 1'b1;
      @(negedge clk);
      chk(aen == 1'b1, "R2 aen after grant", aen, 1);
      finish_wait("R2 completion");
      chk(idx == 2, "R2 cycles run", idx, 2);
      hlda_auto = 1'b1;
      dreq = 1'b0;
   endtask

   task automatic t_read_burst;
      dreq = 1'b1;
      start(16'hFFFE, 5, K_RD, 1'b1);
      finish_wait("R11 burst completion");
      chk(idx == 5, "R8 read burst count", idx, 5);
      chk(falls == 1, "R11 burst keeps bus", falls, 1);
      chk(last_gap == 5, "R11 burst spacing", last_gap, 5);
      chk(stb_cycles == 10, "R4 read strobe cycles", stb_cycles, 10);
      dreq = 1'b0;
   endtask

   task automatic t_write_single;
      dreq = 1'b1;
      start(16'h40FE, 4, K_WR, 1'b0);
      finish_wait("R12 single completion");
      chk(idx == 4, "R5 write cycles", idx, 4);
      chk(falls == 4, "R12 bus released per byte", falls, 4);
      chk(stb_cycles == 8, "R5 write strobe cycles", stb_cycles, 8);
      dreq = 1'b0;
   endtask

   task automatic t_verify(input logic [1:0] k, input int n);
      dreq = 1'b1;
      start(16'h5A00, n, k, 1'b1);
      finish_wait("R6 verify completion");
      chk(stb_cycles == 0, "R6 no strobes", stb_cycles, 0);
      chk(dack_cycles == 4 * n, "R6 ack every cycle", dack_cycles, 4 * n);
      dreq = 1'b0;
   endtask

   task automatic t_tc_one;
      dreq = 1'b1;
      start(16'hFFFF, 1, K_RD, 1'b1);
      finish_wait("R9 single cycle");
      repeat (6) @(negedge clk);
      chk(idx == 1, "R9 exactly one cycle", idx, 1);
      chk(hrq == 1'b0, "R9 idle after tc", hrq, 0);
      dreq = 1'b0;
   endtask

   task automatic t_ready;
      ready = 1'b0;
      dreq = 1'b1;
      start(16'h0100, 2, K_RD, 1'b1);
      begin
         int t = 0;
         while (!mem_rd && t < 100) begin
            @(negedge clk);
            t++;
         end
      end
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk(mem_rd && io_wr, "R7 strobes held in wait", {mem_rd, io_wr}, 2'b11);
      end
      ready = 1'b1;
      finish_wait("R7 completion");
      chk(last_gap == 10, "R7 cycle stretched", last_gap, 10);
      dreq = 1'b0;
   endtask

   task automatic t_dreq_drop;
      dreq = 1'b1;
      start(16'h2000, 10, K_WR, 1'b1);
      wait (idx == 3);
      dreq = 1'b0;
      repeat (8) @(negedge clk);
      chk(idx == 3, "R11 paused at dreq low", idx, 3);
      chk(hrq == 1'b0, "R11 hrq dropped", hrq, 0);
      dreq = 1'b1;
      finish_wait("R11 resume");
      chk(idx == 10, "R11 all cycles", idx, 10);
      chk(falls == 2, "R11 two releases", falls, 2);
      dreq = 1'b0;
   endtask

   task automatic t_mark;
      dreq = 1'b1;
      start(16'h7000, 260, K_VER, 1'b1);
      finish_wait("R10 long run");
      chk(marks == 2, "R10 mark count", marks, 2);
      dreq = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_hold_wait();
      t_read_burst();
      t_write_single();
      t_verify(K_VER, 4);
      t_verify(K_ALT, 2);
      t_tc_one();
      t_ready();
      t_dreq_drop();
      t_mark();
      summary();
   end

endmodule